// File: doc/BRIEF.md
# Burst-of-two DDR SRAM controller

The controller sits between a simple request port and a double-data-rate synchronous SRAM with an 18-bit data bus and a fixed burst of two. Each accepted request turns into one memory transaction. A write of 36 bits goes out as two 18-bit beats. A read collects two 18-bit beats and returns them as a single 36-bit word.

The block runs on one clock at twice the memory clock rate. An internal phase bit divides it down. `mem_k` gives the level of the memory clock: a high cycle is the first half of a memory cycle and a low cycle is the second half. All cycle counts below are in the fast clock. Cycle n is the n-th cycle after the edge that accepted the request.

The memory itself pairs the loaded address with the address whose lowest bit is inverted. The controller therefore passes the user address through unchanged. The first beat always belongs to the loaded address.

Top module: `ddr_b2_ctrl`

## Requirements
- R1: After reset `mem_ld_n` is 1, `mem_d_oe` is 0, `mem_bws_n` is 2'b11 and `rd_valid` is 0. These values hold until the first request is accepted.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. `mem_ld_n` is then 0 in cycles 1 and 2 and is 1 in cycle 3. In cycle 1, `mem_addr` equals the request address, `mem_rw` is 1 for a read and 0 for a write, and `mem_k` is 1.
- R3: `req_ready` is 0 whenever `mem_k` is 1. It is 0 in cycles 1 to 3 after an acceptance and is 1 again in cycle 4.
- R4: For a write, `mem_d_oe` is 1 in cycles 3 and 4 only. `mem_d` carries `req_wdata[17:0]` in cycle 3 and `req_wdata[35:18]` in cycle 4.
- R5: `mem_bws_n` is active low. Bit 0 enables data bits [8:0] and bit 1 enables bits [17:9]. It equals ~`req_be[1:0]` in cycle 3 and ~`req_be[3:2]` in cycle 4 of a write, so the two beats may use different selects. It is 2'b11 in every other cycle.
- R6: For a read, `mem_q` is sampled at the end of cycles 4 and 5. `rd_valid` is 1 in cycle 6 only, with `rd_data` = {beat sampled in cycle 5, beat sampled in cycle 4}.
- R7: A write produces no `rd_valid` pulse.
- R8: A read of address A after a write to A returns the written word under the byte enables. A read of A with its lowest bit inverted returns the two halves swapped, because the memory's burst pairs A with A^1.
- R9: `mem_d_oe` is never 1 in a cycle where read data is due on `mem_q`, and never while `mem_ld_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_rd | input | 1 | 1 = read, 0 = write |
| req_addr | input | AW | Word address |
| req_wdata | input | 2*DW | Write word; low half is the first beat |
| req_be | input | 4 | Active-high enables, two per beat |
| rd_valid | output | 1 | Read word valid for one cycle |
| rd_data | output | 2*DW | Read word |
| mem_k | output | 1 | Memory clock level |
| mem_ld_n | output | 1 | Active-low load strobe |
| mem_rw | output | 1 | 1 = read, 0 = write |
| mem_addr | output | AW | Memory address |
| mem_bws_n | output | 2 | Active-low half-word write selects |
| mem_d | output | DW | Write data beat |
| mem_d_oe | output | 1 | Data bus drive enable |
| mem_q | input | DW | Read data beat |

## Verification
If the phase bit slips, the load strobe, the write beats and the read capture all move half a memory cycle together. That shows up within the first transaction as data on the wrong `mem_k` level or as a swapped read word. A wrong write or read pipeline stage shifts a beat by one cycle, or stretches the drive enable, on the very next burst. Stale write data or stale enables only show up when a beat writes into memory. The error then appears at the ports on the read-back of that address, which comes several transactions later.

// File: rtl/ddr_b2_ctrl.sv
module ddr_b2_ctrl #(
  parameter int AW = 20,
  parameter int DW = 18
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_rd,
  input  logic [AW-1:0]   req_addr,
  input  logic [2*DW-1:0] req_wdata,
  input  logic [3:0]      req_be,
  output logic            rd_valid,
  output logic [2*DW-1:0] rd_data,
  output logic            mem_k,
  output logic            mem_ld_n,
  output logic            mem_rw,
  output logic [AW-1:0]   mem_addr,
  output logic [1:0]      mem_bws_n,
  output logic [DW-1:0]   mem_d,
  output logic            mem_d_oe,
  input  logic [DW-1:0]   mem_q
);
  logic            kph, busy, accept;
  logic [2:0]      wp;
  logic [4:0]      rp;
  logic [2*DW-1:0] wdat;
  logic [3:0]      wbe;
  logic [DW-1:0]   qlo;

  assign mem_k     = kph;
  assign req_ready = !kph && !busy;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kph <= 1'b0;
      busy <= 1'b0;
      mem_ld_n <= 1'b1;
      mem_rw <= 1'b1;
      mem_addr <= '0;
      wp <= '0;
      rp <= '0;
      wdat <= '0;
      wbe <= '0;
    end else begin
      kph <= !kph;
      if (accept) busy <= 1'b1;
      else if (!kph) busy <= 1'b0;
      if (accept) begin
        mem_ld_n <= 1'b0;
        mem_rw <= req_rd;
        mem_addr <= req_addr;
      end else if (!kph) begin
        mem_ld_n <= 1'b1;
      end
      if (accept && !req_rd) begin
        wdat <= req_wdata;
        wbe <= req_be;
      end
      wp <= {wp[1:0], accept && !req_rd};
      rp <= {rp[3:0], accept && req_rd};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_d <= '0;
      mem_d_oe <= 1'b0;
      mem_bws_n <= 2'b11;
    end else begin
      mem_d_oe <= wp[1] || wp[2];
      if (wp[1]) begin
        mem_d <= wdat[DW-1:0];
        mem_bws_n <= ~wbe[1:0];
      end else if (wp[2]) begin
        mem_d <= wdat[2*DW-1:DW];
        mem_bws_n <= ~wbe[3:2];
      end else begin
        mem_bws_n <= 2'b11;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      qlo <= '0;
      rd_data <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (rp[3]) qlo <= mem_q;
      if (rp[4]) rd_data <= {mem_q, qlo};
      rd_valid <= rp[4];
    end
  end

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !mem_ld_n ##1 !mem_ld_n ##1 mem_ld_n);
  p_ready_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready ##1 !req_ready ##1 !req_ready);
  p_oe_noload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_d_oe |-> mem_ld_n);
  p_bws_oe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_bws_n != 2'b11) |-> mem_d_oe);
  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  p_write_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_rd) |-> ##6 !rd_valid);
  p_no_drive_on_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_d_oe |-> !(rp[3] || rp[4]));
endmodule

// File: tb/ddr_b2_ctrl_tb_top.sv
module ddr_b2_ctrl_tb_top;
  localparam int AW = 6;
  localparam int DW = 18;
  localparam int N = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_rd = 0;
  logic [AW-1:0] req_addr = '0;
  logic [2*DW-1:0] req_wdata = '0;
  logic [3:0] req_be = '0;
  logic req_ready, rd_valid, mem_k, mem_ld_n, mem_rw, mem_d_oe;
  logic [2*DW-1:0] rd_data;
  logic [AW-1:0] mem_addr;
  logic [1:0] mem_bws_n;
  logic [DW-1:0] mem_d;
  logic [DW-1:0] mem_q = '0;

  ddr_b2_ctrl #(.AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_rd(req_rd), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_k(mem_k), .mem_ld_n(mem_ld_n),
    .mem_rw(mem_rw), .mem_addr(mem_addr), .mem_bws_n(mem_bws_n), .mem_d(mem_d),
    .mem_d_oe(mem_d_oe), .mem_q(mem_q));

  always #5 clk = !clk;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  logic [DW-1:0] phys [N];
  logic [DW-1:0] refm [N];

  // memory model: burst pairs A then A^1
  int mcnt = 0;
  logic [AW-1:0] maddr;
  logic mrw;
  always @(posedge clk) begin
    if (!mem_ld_n && mem_k) begin
      mcnt <= 1; maddr <= mem_addr; mrw <= mem_rw;
    end else if (mcnt != 0) mcnt <= (mcnt == 4) ? 0 : mcnt + 1;
    if (mcnt == 2 || mcnt == 3) begin
      if (mrw) mem_q <= phys[(mcnt == 2) ? maddr : (maddr ^ 1)];
      else if (mem_d_oe) begin
        if (!mem_bws_n[0]) phys[(mcnt == 2) ? maddr : (maddr ^ 1)][8:0] <= mem_d[8:0];
        if (!mem_bws_n[1]) phys[(mcnt == 2) ? maddr : (maddr ^ 1)][17:9] <= mem_d[17:9];
      end
    end else if (mcnt == 4) mem_q <= '1;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] nw, input logic [1:0] be);
    merge = old;
    if (be[0]) merge[8:0] = nw[8:0];
    if (be[1]) merge[17:9] = nw[17:9];
  endfunction

  task automatic op(input bit rd, input logic [AW-1:0] a, input logic [2*DW-1:0] w, input logic [3:0] be);
    logic [2*DW-1:0] exp;
    exp = {refm[a ^ 1], refm[a]};
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_rd = rd; req_addr = a; req_wdata = w; req_be = be;
    @(posedge clk);
    for (int k = 1; k <= 7; k++) begin
      @(negedge clk);
      if (k == 1) begin
        req_valid = 0;
        chk(!mem_ld_n && mem_addr == a && mem_rw == rd && mem_k, "R2 load", {mem_ld_n, mem_rw, mem_addr}, {1'b0, rd, a});
        chk(!req_ready, "R3 ready k1", req_ready, 0);
      end
      if (k == 2) begin
        chk(!mem_ld_n, "R2 load k2", mem_ld_n, 0);
        chk(!req_ready, "R3 ready k2", req_ready, 0);
      end
      if (k == 3) begin
        chk(mem_ld_n, "R2 load k3", mem_ld_n, 1);
        chk(!req_ready, "R3 ready k3", req_ready, 0);
      end
      if (k == 4) chk(req_ready, "R3 ready k4", req_ready, 1);
      if (!rd && k == 3) begin
        chk(mem_d_oe && mem_d == w[17:0], "R4 beat0", {mem_d_oe, mem_d}, {1'b1, w[17:0]});
        chk(mem_bws_n == ~be[1:0], "R5 sel0", mem_bws_n, ~be[1:0]);
      end else if (!rd && k == 4) begin
        chk(mem_d_oe && mem_d == w[35:18], "R4 beat1", {mem_d_oe, mem_d}, {1'b1, w[35:18]});
        chk(mem_bws_n == ~be[3:2], "R5 sel1", mem_bws_n, ~be[3:2]);
      end else begin
        chk(!mem_d_oe, "R4 oe idle", mem_d_oe, 0);
        chk(mem_bws_n == 2'b11, "R5 sel idle", mem_bws_n, 2'b11);
      end
      if (k == 6) begin
        if (rd) chk(rd_valid && rd_data == exp, "R6 R8 read", {rd_valid, rd_data}, {1'b1, exp});
        else chk(!rd_valid, "R7 write silent", rd_valid, 0);
      end else chk(!rd_valid, "R6 valid pulse", rd_valid, 0);
    end
    if (!rd) begin
      refm[a] = merge(refm[a], w[17:0], be[1:0]);
      refm[a ^ 1] = merge(refm[a ^ 1], w[35:18], be[3:2]);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected<=100000", cyc);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < N; i++) begin phys[i] = '0; refm[i] = '0; end
    repeat (4) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(mem_ld_n && !mem_d_oe && mem_bws_n == 2'b11 && !rd_valid, "R1 reset idle",
          {mem_ld_n, mem_d_oe, mem_bws_n, rd_valid}, 5'b10110);
    end
    // directed corners
    op(0, 6'd4, 36'h1_2345_6789, 4'b1111);
    op(1, 6'd4, '0, 4'b0);
    op(1, 6'd5, '0, 4'b0);
    op(0, 6'd9, 36'hA_BCDE_F012, 4'b1001);
    op(1, 6'd9, '0, 4'b0);
    op(1, 6'd8, '0, 4'b0);
    op(0, 6'd12, 36'hF_FFFF_FFFF, 4'b0000);
    op(1, 6'd12, '0, 4'b0);
    op(0, 6'd20, 36'h5_5555_5555, 4'b0110);
    op(1, 6'd21, '0, 4'b0);
    for (int i = 0; i < 150; i++) begin
      logic [2*DW-1:0] w;
      w = {$urandom, $urandom};
      op($urandom_range(0, 1), AW'($urandom), w, 4'($urandom));
    end
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule